// File: doc/BRIEF.md
# SPI Master with Stopped Clock and Programmable Divider

This block is a single-word SPI master clocked from the system clock. A programmable divide value sets the serial clock period. The serial clock rests low between words. An active-low slave-select frames every word. Data goes out on MOSI and is launched on rising serial clock edges. Data comes in on MISO and is sampled on falling edges. Both directions run most significant bit first.

A transfer starts with a one-cycle `start_i` pulse together with a parallel transmit word. When the last falling edge arrives, the block presents the received word and pulses `done_o`. MOSI is then released to high impedance. Slave-select stays low for one more serial period before the block goes idle.

When the divide value is odd, the low and high phases of the serial clock are equal. When it is even, the low phase is one system cycle shorter than the high phase.

Top module: `spi_clkstop_master`

## Requirements
- R1: The serial clock period is E+1 system cycles, where E is the divide value latched at start; a divide value of 0 behaves as 1.
- R2: The high phase of every bit is floor(E/2)+1 system cycles. The low phase is (E+1) minus the high phase: equal halves for odd E, and E/2 cycles for even E.
- R3: After reset and whenever idle, `sclk_o` is 0, `ss_n_o` is 1, `busy_o` is 0 and `mosi_oe_o` is 0 (MOSI high impedance).
- R4: A start pulls `ss_n_o` low and drives MOSI with bit WORD_W-1 at once. `ss_n_o` stays low for one low phase before the first rising edge.
- R5: MOSI changes only with a rising serial clock edge. Bits go out from bit WORD_W-1 down to bit 0.
- R6: MISO is sampled at each falling edge, MSB first. With the final falling edge, `rx_word_o` holds the received word and `done_o` is high for exactly one cycle.
- R7: MOSI is released (`mosi_oe_o` = 0, `mosi_o` = Z) at the falling edge that ends bit 0.
- R8: `ss_n_o` returns high, and `busy_o` low, one serial period (E+1 cycles) after the final falling edge. `busy_o` is the inverse of `ss_n_o`.
- R9: A start request while busy is ignored: the running word continues unchanged and produces a single `done_o`.
- R10: Changes to `div_i` during a transfer have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Serial clock divide value E |
| start_i | input | 1 | Start pulse, taken only when idle |
| tx_word_i | input | WORD_W | Word to transmit |
| rx_word_o | output | WORD_W | Last received word |
| done_o | output | 1 | One-cycle pulse when the received word is valid |
| busy_o | output | 1 | High from start until slave-select returns high |
| sclk_o | output | 1 | Serial clock, idles low |
| ss_n_o | output | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial data out, Z when released |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | Serial data in |

## Verification
The bench sweeps divide values 0 through 4 and 7, so both the even (asymmetric) and odd (symmetric) phase splits are measured in system cycles. A design that split even periods in half would fail the low- and high-phase width checks. It measures the lead time from slave-select falling to the first rising edge, and the tail from the last falling edge to slave-select rising. An off-by-one counter would show up there. Words with alternating and single-bit patterns expose reversed bit order or a shift that fires on the first rising edge. A restart and a new divide value are presented while busy. A design that accepted either would emit two done pulses, corrupt the transmitted word, or change phase widths within the word.

// File: rtl/spi_clkstop_master.sv
module spi_clkstop_master #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              ss_n_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i
);
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_TAIL} state_t;

  state_t             state;
  logic [DIV_W-1:0]   div_q, cnt, div_eff, lo_len, hi_len;
  logic [WORD_W-1:0]  tx_sh, rx_sh;
  logic [BIT_W-1:0]   bit_n;

  assign div_eff   = (div_q == '0) ? DIV_W'(1) : div_q;
  assign hi_len    = (div_eff >> 1) + DIV_W'(1);
  assign lo_len    = div_eff[0] ? hi_len : (div_eff >> 1);
  assign busy_o    = (state != S_IDLE);
  assign ss_n_o    = ~busy_o;
  assign mosi_o    = mosi_oe_o ? tx_sh[WORD_W-1] : 1'bz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      div_q     <= '0;
      cnt       <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      bit_n     <= '0;
      sclk_o    <= 1'b0;
      mosi_oe_o <= 1'b0;
      done_o    <= 1'b0;
      rx_word_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (start_i) begin
            div_q     <= div_i;
            tx_sh     <= tx_word_i;
            bit_n     <= '0;
            mosi_oe_o <= 1'b1;
            state     <= S_LEAD;
          end
        end
        S_LEAD: begin
          if (cnt == lo_len - DIV_W'(1)) begin
            cnt    <= '0;
            sclk_o <= 1'b1;
            state  <= S_SHIFT;
          end else begin
            cnt <= cnt + DIV_W'(1);
          end
        end
        S_SHIFT: begin
          if (sclk_o) begin
            if (cnt == hi_len - DIV_W'(1)) begin
              cnt    <= '0;
              sclk_o <= 1'b0;
              rx_sh  <= {rx_sh[WORD_W-2:0], miso_i};
              if (bit_n == BIT_W'(WORD_W - 1)) begin
                mosi_oe_o <= 1'b0;
                done_o    <= 1'b1;
                rx_word_o <= {rx_sh[WORD_W-2:0], miso_i};
                state     <= S_TAIL;
              end else begin
                bit_n <= bit_n + BIT_W'(1);
              end
            end else begin
              cnt <= cnt + DIV_W'(1);
            end
          end else begin
            if (cnt == lo_len - DIV_W'(1)) begin
              cnt    <= '0;
              sclk_o <= 1'b1;
              tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
            end else begin
              cnt <= cnt + DIV_W'(1);
            end
          end
        end
        S_TAIL: begin
          if (cnt == div_eff) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + DIV_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_clkstop_master_chk.sv
module spi_clkstop_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk_o,
  input logic ss_n_o,
  input logic busy_o,
  input logic mosi_o,
  input logic mosi_oe_o,
  input logic done_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && !mosi_oe_o)); // R3
  AST_CLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !ss_n_o); // R4
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mosi_oe_o && $past(mosi_oe_o) && !$rose(sclk_o)) |-> $stable(mosi_o)); // R5
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(sclk_o)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_RELEASE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mosi_oe_o); // R7
  AST_SS_HIGH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n_o) |-> (!sclk_o && !mosi_oe_o)); // R8
endmodule

bind spi_clkstop_master spi_clkstop_master_chk u_chk (.*);

// File: tb/test_spi_clkstop_master.sv
`timescale 1ns/1ps
module test_spi_clkstop_master;
  localparam int W  = 8;
  localparam int DW = 8;

  typedef struct {
    logic [W-1:0] tx;
    logic [W-1:0] rx;
    int lo, hi, per;
  } item_t;

  logic clk = 0, rst_n = 0, start_i = 0, miso_i = 0;
  logic [DW-1:0] div_i = '0;
  logic [W-1:0] tx_word_i = '0, rx_word_o, slave_word = '0;
  logic done_o, busy_o, sclk_o, ss_n_o, mosi_o, mosi_oe_o;

  spi_clkstop_master #(.WORD_W(W), .DIV_W(DW)) i_spi_clkstop_master (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .start_i(start_i),
    .tx_word_i(tx_word_i), .rx_word_o(rx_word_o), .done_o(done_o),
    .busy_o(busy_o), .sclk_o(sclk_o), .ss_n_o(ss_n_o), .mosi_o(mosi_o),
    .mosi_oe_o(mosi_oe_o), .miso_i(miso_i));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  item_t q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] d, input logic [W-1:0] tx,
                      input logic [W-1:0] sw, input bit poke);
    item_t it;
    int e;
    e = (d == 0) ? 1 : int'(d);
    it.tx = tx; it.rx = sw; it.per = e + 1; it.hi = e / 2 + 1; it.lo = it.per - it.hi;
    @(negedge clk);
    slave_word = sw;
    @(negedge clk);
    div_i = d; tx_word_i = tx; start_i = 1; q.push_back(it);
    @(negedge clk);
    start_i = 0;
    div_i = d + 8'd3;  // R10: changed while busy
    if (poke) begin
      repeat (3) @(negedge clk);
      tx_word_i = ~tx; div_i = 8'd6; start_i = 1;  // R9: restart while busy
      @(negedge clk);
      start_i = 0;
    end
    while (!ss_n_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  logic prev_sclk = 0, prev_ss = 1;
  logic [W-1:0] mosi_word = '0;
  int lo_cnt = 0, hi_cnt = 0, tail_cnt = 0, sidx = 0, dones = 0, rises = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ss_n_o) begin
        miso_i <= slave_word[W-1];
        sidx = 0;
      end
      if (prev_ss && !ss_n_o) begin
        lo_cnt = 1; rises = 0; dones = 0;
        chk(mosi_oe_o === 1'b1 && mosi_o === q[0].tx[W-1], "R4 msb at select",
            mosi_o, q[0].tx[W-1]);
      end else if (!ss_n_o && sclk_o && !prev_sclk) begin
        chk(lo_cnt == q[0].lo, rises == 0 ? "R4 lead low" : "R2 low phase", lo_cnt, q[0].lo);
        hi_cnt = 1;
        rises++;
        mosi_word = {mosi_word[W-2:0], mosi_o};
      end else if (!ss_n_o && !sclk_o && prev_sclk) begin
        chk(hi_cnt == q[0].hi, "R2 high phase", hi_cnt, q[0].hi);
        chk(hi_cnt + lo_cnt == q[0].per, "R1 period", hi_cnt + lo_cnt, q[0].per);
        sidx++;
        if (sidx < W) miso_i <= slave_word[W-1-sidx];
        lo_cnt = 1; tail_cnt = 1;
      end else if (!ss_n_o && sclk_o) begin
        hi_cnt++;
      end else if (!ss_n_o) begin
        lo_cnt++; tail_cnt++;
      end
      if (done_o) begin
        dones++;
        chk(rx_word_o == q[0].rx, "R6 rx word", rx_word_o, q[0].rx);
        chk(rises == W && prev_sclk && !sclk_o, "R6 done at last fall", rises, W);
        chk(mosi_oe_o === 1'b0 && mosi_o === 1'bz, "R7 mosi released", mosi_oe_o, 0);
        chk(mosi_word == q[0].tx, "R5 mosi word", mosi_word, q[0].tx);
      end
      if (!prev_ss && ss_n_o) begin
        chk(tail_cnt == q[0].per, "R8 tail", tail_cnt, q[0].per);
        chk(busy_o == 1'b0, "R8 busy low", busy_o, 0);
        chk(dones == 1, "R9 single done", dones, 1);
        void'(q.pop_front());
      end
      chk(busy_o == !ss_n_o, "R8 busy vs select", busy_o, !ss_n_o);
      prev_sclk = sclk_o;
      prev_ss = ss_n_o;
    end
  end

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    chk(sclk_o == 0 && ss_n_o == 1 && busy_o == 0 && mosi_oe_o == 0 && done_o == 0,
        "R3 reset state", {sclk_o, ss_n_o, busy_o, mosi_oe_o}, 4'b0100);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(sclk_o == 0 && ss_n_o == 1 && mosi_o === 1'bz, "R3 idle", sclk_o, 0);
    send(8'd1, 8'hA5, 8'h3C, 0);
    send(8'd2, 8'h81, 8'h7E, 0);
    send(8'd3, 8'h55, 8'hAA, 1);
    send(8'd4, 8'h01, 8'h80, 0);
    send(8'd0, 8'hFF, 8'h00, 0);
    send(8'd7, 8'h96, 8'hC3, 1);
    send(8'd2, 8'h00, 8'hFF, 0);
    chk(q.size() == 0, "R6 all words returned", q.size(), 0);
    repeat (3) @(negedge clk);
    chk(sclk_o == 0 && ss_n_o == 1 && mosi_oe_o == 0, "R3 idle after", sclk_o, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule